// File: doc/BRIEF.md
# Input Capture Glitch Filter

This block sits in front of a timer's input-capture logic and keeps narrow pulses on the capture pin from reaching it. The raw pin is first brought into the bus clock domain. Every selected edge of the synchronized level starts a wait of a programmed number of bus cycles. When the wait ends, the filter compares the current level with the level that was held just before the edge. It emits a one-cycle qualified pulse only if the pin has stayed on the new side. A glitch that returns to its old level before the recheck produces nothing.

The wait length comes from an 8-bit delay code and a precision bit. In fine mode, the whole code gives a wait of (code+1)*4 cycles. In coarse mode, only the two low bits count. They select one of three long waits, or they switch the filter off so that edges pass straight through. A selected edge that arrives while a wait is in progress is dropped. The configuration is read when an edge starts a wait, so a change in mid-wait takes effect only from the next edge.

Top module: `capture_glitch_filter`

## Requirements
- R1: The pin goes through a two-flop synchronizer. With an effective wait of D cycles, a qualified pulse is high in the cycle that follows the (D+3)-th rising clock edge after the pin changes.
- R2: When `fine_mode` is 1, the wait is D = (`dly_code`+1)*4 cycles, so codes 0..255 give waits of 4..1024 cycles.
- R3: When `fine_mode` is 0, bits [1:0] of `dly_code` pick the wait: 01 gives 256 cycles, 10 gives 512 and 11 gives 1024. Bits [7:2] have no effect.
- R4: When `fine_mode` is 0 and `dly_code[1:0]` is 00, the filter is bypassed. Every selected edge gives a pulse 3 cycles after the pin change, with no recheck and no busy period.
- R5: At the end of the wait, a pulse is produced only if the synchronized level differs from the level sampled one cycle before the edge. A glitch of g cycles is rejected when g <= D and passed when g > D.
- R6: `edge_sel` chooses the edges that start a wait: 00 none, 01 rising only, 10 falling only, 11 both. Edges of a kind that is not selected are ignored.
- R7: A selected edge detected while a wait is running is ignored. Edges are accepted again from the cycle after the recheck.
- R8: A change to `dly_code` or `fine_mode` during a wait leaves the length of that wait unchanged. The new value governs the next accepted edge.
- R9: While `rst_n` is low at a clock edge, `qual_pulse` is 0, any wait in progress is cancelled and the synchronizer is cleared to 0.
- R10: Each qualified edge gives exactly one cycle of `qual_pulse` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_raw | input | 1 | Asynchronous capture pin |
| edge_sel | input | 2 | Edge selection: 00 none, 01 rising, 10 falling, 11 both |
| dly_code | input | 8 | Delay code |
| fine_mode | input | 1 | 1 = fine (code+1)*4 wait, 0 = coarse two-bit code |
| qual_pulse | output | 1 | One-cycle qualified edge pulse |

## Verification
Two events can fall in the same cycle: the recheck that ends a wait, and the arrival of the return edge of a pulse. The bench drives pulses of width D and D+1 for every edge selection, both start levels and a spread of fine and coarse codes. A width of D puts the return edge inside the wait, so it must be dropped and the recheck must reject the pulse. A width of D+1 makes the edge land on the first cycle after the recheck, so both pulses must appear. Every expected pulse count and cycle is worked out arithmetically from D and the pulse width.

// File: rtl/cgf_pkg.sv
// Package: shared types and helper functions for the capture glitch filter.
// Assumes: nothing beyond IEEE 1800-2017 constant function evaluation.
package cgf_pkg;

    // Edge selection encoding seen on the edge_sel port.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    // Larger of two unsigned values, for parameter derivation.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cgf_sync.sv
// Module: cgf_sync
// Brings an asynchronous pin into the clock domain with a STAGES-deep flop
// chain and also provides the synchronized level one cycle older.
// Assumes: STAGES >= 2; the reset value of every stage is 0.
module cgf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic lvl,
    output logic lvl_prev
);

    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the pin through the synchronizer and one extra history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], pin_raw};
        end
    end

    assign lvl      = chain_q[STAGES-1];
    assign lvl_prev = chain_q[STAGES];

endmodule

// File: rtl/cgf_edge_detect.sv
// Module: cgf_edge_detect
// Flags a selected edge of the synchronized level in the cycle in which the
// new level first appears.
// Assumes: lvl_prev is lvl delayed by exactly one clock.
module cgf_edge_detect
    import cgf_pkg::*;
(
    input  logic       lvl,
    input  logic       lvl_prev,
    input  logic [1:0] edge_sel,
    output logic       edge_hit
);

    edge_mode_e mode;
    logic       rise;
    logic       fall;

    // Classify the transition and match it against the selection.
    always_comb begin
        mode     = edge_mode_e'(edge_sel);
        rise     = lvl & ~lvl_prev;
        fall     = ~lvl & lvl_prev;
        unique case (mode)
            EDGE_NONE: edge_hit = 1'b0;
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cgf_delay_sel.sv
// Module: cgf_delay_sel
// Turns the delay code and precision bit into a wait length in cycles.
// A length of zero means bypass.
// Assumes: DLY_W >= 2; the coarse lengths are 2**(BASE_LOG2-1+code) for
// codes 1..3.
module cgf_delay_sel #(
    parameter int unsigned DLY_W     = 8,
    parameter int unsigned STEP_LOG2 = 2,
    parameter int unsigned BASE_LOG2 = 8,
    parameter int unsigned LEN_W     = 11
) (
    input  logic [DLY_W-1:0] dly_code,
    input  logic             fine_mode,
    output logic [LEN_W-1:0] dly_len
);

    logic [LEN_W-1:0] fine_len;
    logic [LEN_W-1:0] coarse_len;

    // Compute both candidate lengths and pick one by mode.
    always_comb begin
        fine_len = (LEN_W'(dly_code) + LEN_W'(1)) << STEP_LOG2;
        if (dly_code[1:0] == 2'b00) begin
            coarse_len = '0;
        end else begin
            coarse_len = LEN_W'(1) << (BASE_LOG2 - 1 + 32'(dly_code[1:0]));
        end
        dly_len = fine_mode ? fine_len : coarse_len;
    end

endmodule

// File: rtl/cgf_qualifier.sv
// Module: cgf_qualifier
// Runs the wait counter. It captures the pre-edge level on an accepted
// edge, counts down and rechecks the level at the end of the wait, then
// emits the pulse.
// Assumes: dly_len is either 0 (bypass) or between 1 and 2**CNT_W.
module cgf_qualifier #(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_hit,
    input  logic             lvl,
    input  logic             lvl_prev,
    input  logic [LEN_W-1:0] dly_len,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             ref_lvl,
    output logic             qual_pulse
);

    logic bypass;

    assign bypass = (dly_len == '0);

    // Wait state machine: load on an accepted edge, count down, recheck at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cnt        <= '0;
            ref_lvl    <= 1'b0;
            qual_pulse <= 1'b0;
        end else begin
            qual_pulse <= 1'b0;
            if (busy) begin
                if (cnt == '0) begin
                    busy       <= 1'b0;
                    qual_pulse <= (lvl != ref_lvl);
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end else if (edge_hit) begin
                if (bypass) begin
                    qual_pulse <= 1'b1;
                end else begin
                    busy    <= 1'b1;
                    cnt     <= CNT_W'(dly_len - LEN_W'(1));
                    ref_lvl <= lvl_prev;
                end
            end
        end
    end

endmodule

// File: rtl/capture_glitch_filter.sv
// Module: capture_glitch_filter (top)
// Qualifies edges on a capture pin with a delay-then-recheck filter.
// Assumes: pin_raw is asynchronous; the bus clock is clk; reset is
// synchronous and active low.
module capture_glitch_filter
    import cgf_pkg::*;
#(
    parameter int unsigned DLY_W       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned STEP_LOG2   = 2,
    parameter int unsigned BASE_LOG2   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic [1:0]       edge_sel,
    input  logic [DLY_W-1:0] dly_code,
    input  logic             fine_mode,
    output logic             qual_pulse
);

    localparam int unsigned FINE_MAX   = (2 ** DLY_W) << STEP_LOG2;
    localparam int unsigned COARSE_MAX = 1 << (BASE_LOG2 + 2);
    localparam int unsigned MAX_LEN    = max_u(FINE_MAX, COARSE_MAX);
    localparam int unsigned CNT_W      = $clog2(MAX_LEN);
    localparam int unsigned LEN_W      = CNT_W + 1;

    logic             sync_lvl;
    logic             sync_prev;
    logic             edge_hit;
    logic [LEN_W-1:0] dly_len;
    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             ref_lvl;

    cgf_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_raw),
        .lvl      (sync_lvl),
        .lvl_prev (sync_prev)
    );

    cgf_edge_detect i_edge (
        .lvl      (sync_lvl),
        .lvl_prev (sync_prev),
        .edge_sel (edge_sel),
        .edge_hit (edge_hit)
    );

    cgf_delay_sel #(
        .DLY_W     (DLY_W),
        .STEP_LOG2 (STEP_LOG2),
        .BASE_LOG2 (BASE_LOG2),
        .LEN_W     (LEN_W)
    ) i_dsel (
        .dly_code  (dly_code),
        .fine_mode (fine_mode),
        .dly_len   (dly_len)
    );

    cgf_qualifier #(
        .CNT_W (CNT_W),
        .LEN_W (LEN_W)
    ) i_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_hit   (edge_hit),
        .lvl        (sync_lvl),
        .lvl_prev   (sync_prev),
        .dly_len    (dly_len),
        .busy       (busy),
        .cnt        (cnt),
        .ref_lvl    (ref_lvl),
        .qual_pulse (qual_pulse)
    );

endmodule

// File: rtl/cgf_checker.sv
// Module: cgf_checker
// Temporal properties of the capture glitch filter. It is attached to the
// top module by the bind statement at the end of this file.
// Assumes: it sees the top's ports and its internal wait state.
module cgf_checker #(
    parameter int unsigned DLY_W     = 8,
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned STEP_LOG2 = 2,
    parameter int unsigned BASE_LOG2 = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       edge_sel,
    input logic [DLY_W-1:0] dly_code,
    input logic             fine_mode,
    input logic             qual_pulse,
    input logic             busy,
    input logic [CNT_W-1:0] cnt,
    input logic             sync_lvl,
    input logic             ref_lvl
);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !qual_pulse && !busy);

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cnt != '0 |=> busy && cnt == $past(cnt) - CNT_W'(1));

    // R7
    count_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cnt == '0 |=> !busy);

    // R5
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cnt == '0 && sync_lvl == ref_lvl |=> !qual_pulse);

    // R5
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cnt == '0 && sync_lvl != ref_lvl |=> qual_pulse);

    // R2
    fine_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && $past(fine_mode) |->
            32'(cnt) == ((32'($past(dly_code)) + 1) << STEP_LOG2) - 1);

    // R3
    coarse_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && !$past(fine_mode) |->
            32'(cnt) == (1 << (BASE_LOG2 - 1 + 32'($past(dly_code[1:0])))) - 1);

    // R6
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_sel == 2'b00 && !busy |=> !busy);

endmodule

bind capture_glitch_filter cgf_checker #(
    .DLY_W     (DLY_W),
    .CNT_W     (CNT_W),
    .STEP_LOG2 (STEP_LOG2),
    .BASE_LOG2 (BASE_LOG2)
) i_cgf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_sel   (edge_sel),
    .dly_code   (dly_code),
    .fine_mode  (fine_mode),
    .qual_pulse (qual_pulse),
    .busy       (busy),
    .cnt        (cnt),
    .sync_lvl   (sync_lvl),
    .ref_lvl    (ref_lvl)
);

// File: tb/test_capture_glitch_filter.sv
// Bench: sweeps edge selection, start level, delay code and glitch width.
// Expected pulse counts and cycles are derived arithmetically.
module test_capture_glitch_filter;

    logic       clk;
    logic       rst_n;
    logic       pin_raw;
    logic [1:0] edge_sel;
    logic [7:0] dly_code;
    logic       fine_mode;
    logic       qual_pulse;

    int checks;
    int errors;
    int cyc;
    int pcnt;
    int p0;
    int p1;

    capture_glitch_filter i_capture_glitch_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_raw    (pin_raw),
        .edge_sel   (edge_sel),
        .dly_code   (dly_code),
        .fine_mode  (fine_mode),
        .qual_pulse (qual_pulse)
    );

    // 250 MHz clock.
    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Count rising edges.
    always @(posedge clk) cyc <= cyc + 1;

    // Record the cycle of every pulse cycle seen.
    always @(negedge clk) begin
        if (qual_pulse) begin
            if (pcnt == 0) p0 = cyc;
            if (pcnt == 1) p1 = cyc;
            pcnt = pcnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_rec();
        pcnt = 0;
        p0   = -1;
        p1   = -1;
    endtask

    function automatic int delay_of(input bit fine, input int code);
        if (fine) return (code + 1) * 4;
        if ((code % 4) == 0) return 0;
        return 128 << (code % 4);
    endfunction

    // One pulse of width g away from level lv; compare against the arithmetic model.
    task automatic glitch_case(input int sel, input int lv, input bit fine,
                               input int code, input int g, input string req);
        int  d;
        int  n;
        bit  s1;
        bit  s2;
        int  ecnt;
        int  e0;
        int  e1;
        d = delay_of(fine, code);
        @(negedge clk);
        edge_sel  = 2'(sel);
        fine_mode = fine;
        dly_code  = 8'(code);
        pin_raw   = lv[0];
        repeat (d + 8) @(negedge clk);
        clear_rec();
        n       = cyc;
        pin_raw = ~lv[0];
        repeat (g) @(negedge clk);
        pin_raw = lv[0];
        repeat (d + 12) @(negedge clk);
        s1   = (lv == 0) ? sel[0] : sel[1];
        s2   = (lv == 0) ? sel[1] : sel[0];
        ecnt = 0;
        e0   = -1;
        e1   = -1;
        if (s1 && g > d) begin
            e0   = n + d + 3;
            ecnt = 1;
        end
        if (s2 && (!s1 || g > d)) begin
            if (ecnt == 0) e0 = n + g + d + 3;
            else           e1 = n + g + d + 3;
            ecnt++;
        end
        check(pcnt == ecnt, {req, " count"}, pcnt, ecnt);
        check(p0 == e0, {req, " first cycle"}, p0, e0);
        check(p1 == e1, {req, " second cycle"}, p1, e1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int fine_codes[7] = '{0, 1, 2, 3, 5, 31, 63};
        int d;
        int n;
        checks    = 0;
        errors    = 0;
        cyc       = 0;
        clear_rec();
        rst_n     = 1'b0;
        pin_raw   = 1'b0;
        edge_sel  = 2'b11;
        dly_code  = 8'd0;
        fine_mode = 1'b1;
        repeat (4) @(negedge clk);
        // R9: output held low in reset
        check(qual_pulse == 1'b0, "R9 reset output", int'(qual_pulse), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(pcnt == 0, "R9 quiet after reset", pcnt, 0);

        // R2 R5 R6 R7 R10: fine mode sweep
        for (int sel = 0; sel < 4; sel++) begin
            for (int lv = 0; lv < 2; lv++) begin
                foreach (fine_codes[i]) begin
                    d = delay_of(1'b1, fine_codes[i]);
                    glitch_case(sel, lv, 1'b1, fine_codes[i], d, "R5 R7 fine width=D");
                    glitch_case(sel, lv, 1'b1, fine_codes[i], d + 1, "R2 R6 R10 fine width=D+1");
                end
            end
        end

        // R3 R4: coarse mode sweep, upper code bits set to show they are ignored
        for (int sel = 0; sel < 4; sel++) begin
            for (int lv = 0; lv < 2; lv++) begin
                for (int c = 0; c < 4; c++) begin
                    d = delay_of(1'b0, c);
                    if (d == 0) begin
                        glitch_case(sel, lv, 1'b0, 8'hB4 | c, 1, "R4 bypass width=1");
                        glitch_case(sel, lv, 1'b0, 8'h48 | c, 2, "R4 bypass width=2");
                    end else begin
                        glitch_case(sel, lv, 1'b0, 8'hB4 | c, d, "R3 coarse width=D");
                        glitch_case(sel, lv, 1'b0, 8'h48 | c, d + 1, "R3 R1 coarse width=D+1");
                    end
                end
            end
        end

        // R8: rewrite the code during a wait; the wait keeps its length of 16
        @(negedge clk);
        edge_sel  = 2'b11;
        fine_mode = 1'b1;
        dly_code  = 8'd3;
        pin_raw   = 1'b0;
        repeat (30) @(negedge clk);
        clear_rec();
        n       = cyc;
        pin_raw = 1'b1;
        repeat (5) @(negedge clk);
        dly_code = 8'd1;
        repeat (30) @(negedge clk);
        check(pcnt == 1, "R8 mid-wait write count", pcnt, 1);
        check(p0 == n + 16 + 3, "R8 mid-wait write keeps old length", p0, n + 19);
        clear_rec();
        n       = cyc;
        pin_raw = 1'b0;
        repeat (30) @(negedge clk);
        check(p0 == n + 8 + 3, "R8 new code applies to next edge", p0, n + 11);

        // R9: reset in mid-wait cancels the wait
        clear_rec();
        pin_raw = 1'b1;
        repeat (6) @(negedge clk);
        rst_n   = 1'b0;
        pin_raw = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check(pcnt == 0, "R9 reset cancels wait", pcnt, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule